// File: doc/BRIEF.md
# Trace Stop Region Controller

This block sits beside an instruction-trace unit and watches the instructions it retires. Software programs a small set of address windows, each with an inclusive lower bound, an inclusive upper bound and its own enable bit. Some retired events can land in one of these windows: a taken branch whose target is inside it, a write to the page-table base register issued from inside it, or a control write that switches tracing on while executing inside it. When such an event lands in a window while tracing is triggered and the current context is enabled, the block performs a stop action.

A stop action latches a sticky stopped flag. That flag pulls the trigger enable low and also holds the filter enable low. The block then sends a two-byte stop marker on a byte-wide valid/ready stream. The flag stays set until software writes the status register. Packets already buffered further down the trace path are not flushed. Software must clear the master enable before it reads the collected trace.

Top module: `trace_stop_ctrl`

## Requirements
- R1: After reset `stopped` is 0, `trig_en` is 0 (master enable off), `pkt_valid` is 0 and no window is enabled.
- R2: `trig_en` equals the master enable (register 0, bit 0) AND NOT `stopped`.
- R3: An IP hits window i only when window i is enabled (register 2, bit i) and base_i <= IP <= limit_i, bounds inclusive (base_i at register 4+2i, limit_i at register 5+2i). A window whose base is above its limit never hits, and a disabled window never hits.
- R4: Event codes 1 (taken branch, IP = target), 2 (page-table base write) and 3 (trace-enabling control write) can cause a stop. Code 0 never does.
- R5: A stop occurs only when both `trig_en` and `ctx_en` are 1 in the cycle of the event.
- R6: A stop sets `stopped` at the next clock edge. `stopped` then stays 1 until software writes register 1, whose bit 0 becomes the new value. If a stop and that write fall in the same cycle, the stop wins.
- R7: `filt_en` equals `filt_req` AND NOT `stopped`.
- R8: In the cycle after a stop event, `pkt_valid` is 1 with `pkt_data` = 0x02. After that byte is accepted, 0x83 is presented, and after that byte is accepted `pkt_valid` returns to 0.
- R9: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid` and `pkt_data` hold their values.
- R10: While `stopped` is 1, or while a stop packet is still being transferred, a qualifying event causes no stop and no packet.
- R11: When software sets `stopped` by writing 1 to register 1, `trig_en` drops and no packet is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A retired event is presented this cycle |
| evt_kind | input | 2 | Event code (0 none, 1 branch, 2 page-table base write, 3 trace-on write) |
| evt_ip | input | ADDR_W | IP checked against the windows |
| ctx_en | input | 1 | Current context is enabled for tracing |
| filt_req | input | 1 | Filter enable from the address filter |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| trig_en | output | 1 | Trigger enable |
| filt_en | output | 1 | Filter enable after stop forcing |
| stopped | output | 1 | Sticky stopped status |
| pkt_valid | output | 1 | Stop packet byte valid |
| pkt_data | output | 8 | Stop packet byte |
| pkt_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench probes each window edge one address inside and one outside. It also covers an inverted window and a disabled window. A comparator with a strict bound, or one that ignores its enable, would stop tracing on the wrong IP. It checks that event code 0 and a cleared context enable never stop. A design missing that gating would emit packets for instructions that were never traced. It stalls the stream between the two bytes, and it fires events while `stopped` is set and while a packet is still in flight. A block that drops held bytes, re-arms early or ignores the sticky flag would emit a corrupt or duplicate marker.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_BRANCH   = 2'd1,
        EV_PTB_WR   = 2'd2,
        EV_TRACE_ON = 2'd3
    } evt_kind_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HDR  = 2'd1,
        TX_SUB  = 2'd2
    } tx_state_e;

    localparam logic [7:0] STOP_HDR_BYTE = 8'h02;
    localparam logic [7:0] STOP_SUB_BYTE = 8'h83;

    localparam int REG_CTL      = 0;
    localparam int REG_STAT     = 1;
    localparam int REG_RANGE_EN = 2;
    localparam int REG_WIN_BASE = 4;
endpackage

// File: rtl/tsr_range_match.sv
module tsr_range_match #(
    parameter int ADDR_W     = 32,
    parameter int NUM_RANGES = 4
) (
    input  logic [ADDR_W-1:0]            ip,
    input  logic [NUM_RANGES*ADDR_W-1:0] lo_flat,
    input  logic [NUM_RANGES*ADDR_W-1:0] hi_flat,
    input  logic [NUM_RANGES-1:0]        win_en,
    output logic                         any_hit
);
    logic [NUM_RANGES-1:0] per_hit;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        logic [ADDR_W-1:0] lo_w;
        logic [ADDR_W-1:0] hi_w;
        assign lo_w       = lo_flat[g*ADDR_W +: ADDR_W];
        assign hi_w       = hi_flat[g*ADDR_W +: ADDR_W];
        assign per_hit[g] = win_en[g] && (ip >= lo_w) && (ip <= hi_w);
    end

    assign any_hit = |per_hit;
endmodule

// File: rtl/tsr_pkt_tx.sv
module tsr_pkt_tx
    import tsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       pkt_ready,
    output logic       pkt_valid,
    output logic [7:0] pkt_data,
    output logic       tx_idle
);
    typedef struct packed {
        tx_state_e st;
    } tx_regs_t;

    tx_regs_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q.st)
            TX_IDLE: if (start) tx_d.st = TX_HDR;
            TX_HDR:  if (pkt_ready) tx_d.st = TX_SUB;
            TX_SUB:  if (pkt_ready) tx_d.st = TX_IDLE;
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '{st: TX_IDLE};
        else        tx_q <= tx_d;
    end

    assign pkt_valid = (tx_q.st != TX_IDLE);
    assign pkt_data  = (tx_q.st == TX_SUB) ? STOP_SUB_BYTE : STOP_HDR_BYTE;
    assign tx_idle   = (tx_q.st == TX_IDLE);
endmodule

// File: rtl/trace_stop_ctrl.sv
module trace_stop_ctrl
    import tsr_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int NUM_RANGES = 4,
    localparam int CFG_AW     = $clog2(REG_WIN_BASE + 2*NUM_RANGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [ADDR_W-1:0] evt_ip,
    input  logic              ctx_en,
    input  logic              filt_req,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              trig_en,
    output logic              filt_en,
    output logic              stopped,
    output logic              pkt_valid,
    output logic [7:0]        pkt_data,
    input  logic              pkt_ready
);
    typedef struct packed {
        logic                         master;
        logic                         stop;
        logic [NUM_RANGES-1:0]        win_en;
        logic [NUM_RANGES*ADDR_W-1:0] lo;
        logic [NUM_RANGES*ADDR_W-1:0] hi;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic any_hit;
    logic tx_idle;
    logic stop_fire;

    tsr_range_match #(
        .ADDR_W    (ADDR_W),
        .NUM_RANGES(NUM_RANGES)
    ) u_match (
        .ip     (evt_ip),
        .lo_flat(r_q.lo),
        .hi_flat(r_q.hi),
        .win_en (r_q.win_en),
        .any_hit(any_hit)
    );

    assign trig_en = r_q.master && !r_q.stop;

    assign stop_fire = evt_valid && (evt_kind != EV_NONE) && any_hit
                    && trig_en && ctx_en && tx_idle;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            if (cfg_addr == CFG_AW'(REG_CTL))      r_d.master = cfg_wdata[0];
            if (cfg_addr == CFG_AW'(REG_STAT))     r_d.stop   = cfg_wdata[0];
            if (cfg_addr == CFG_AW'(REG_RANGE_EN)) r_d.win_en = cfg_wdata[NUM_RANGES-1:0];
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (cfg_addr == CFG_AW'(REG_WIN_BASE + 2*i))
                    r_d.lo[i*ADDR_W +: ADDR_W] = cfg_wdata;
                if (cfg_addr == CFG_AW'(REG_WIN_BASE + 2*i + 1))
                    r_d.hi[i*ADDR_W +: ADDR_W] = cfg_wdata;
            end
        end
        if (stop_fire) r_d.stop = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    tsr_pkt_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (stop_fire),
        .pkt_ready(pkt_ready),
        .pkt_valid(pkt_valid),
        .pkt_data (pkt_data),
        .tx_idle  (tx_idle)
    );

    assign stopped = r_q.stop;
    assign filt_en = filt_req && !r_q.stop;
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
    parameter int CFG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_en,
    input logic              ctx_en,
    input logic              filt_en,
    input logic              stopped,
    input logic              pkt_valid,
    input logic [7:0]        pkt_data,
    input logic              pkt_ready,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr
);
    assert_trig_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !trig_en);

    assert_filter_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !filt_en);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !(cfg_we && cfg_addr == CFG_AW'(1))) |=> stopped);

    assert_first_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> (pkt_data == 8'h02));

    assert_second_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && pkt_data == 8'h02) |=> (pkt_valid && pkt_data == 8'h83));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

    assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> $past(trig_en && ctx_en));

    assert_stop_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> stopped);
endmodule

bind trace_stop_ctrl tsr_checker #(.CFG_AW(CFG_AW)) u_tsr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_en  (trig_en),
    .ctx_en   (ctx_en),
    .filt_en  (filt_en),
    .stopped  (stopped),
    .pkt_valid(pkt_valid),
    .pkt_data (pkt_data),
    .pkt_ready(pkt_ready),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr)
);

// File: tb/tb_trace_stop_ctrl.sv
module tb_trace_stop_ctrl;
    localparam int ADDR_W = 32;
    localparam int CFG_AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_valid = 1'b0;
    logic [1:0]        evt_kind = 2'd0;
    logic [ADDR_W-1:0] evt_ip = '0;
    logic              ctx_en = 1'b0;
    logic              filt_req = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              trig_en, filt_en, stopped, pkt_valid;
    logic [7:0]        pkt_data;
    logic              pkt_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trace_stop_ctrl #(.ADDR_W(ADDR_W), .NUM_RANGES(4)) dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_ip(evt_ip), .ctx_en(ctx_en), .filt_req(filt_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .trig_en(trig_en),
        .filt_en(filt_en), .stopped(stopped), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_ready(pkt_ready)
    );

    // Vector fields: [35:34] event code, [33] ctx_en, [32] stop expected, [31:0] IP
    localparam logic [35:0] VECS [12] = '{
        {2'd1, 1'b1, 1'b1, 32'h0000_1000},  // R3 lower bound inclusive
        {2'd2, 1'b1, 1'b1, 32'h0000_1FFF},  // R3 upper bound inclusive, R4 code 2
        {2'd1, 1'b1, 1'b0, 32'h0000_0FFF},  // R3 just below
        {2'd1, 1'b1, 1'b0, 32'h0000_2000},  // R3 just above
        {2'd3, 1'b1, 1'b1, 32'h0000_8000},  // R3 single-address window, R4 code 3
        {2'd1, 1'b1, 1'b0, 32'h0000_8001},  // R3 outside single window
        {2'd1, 1'b1, 1'b0, 32'h0000_2800},  // R3 inverted window never hits
        {2'd1, 1'b1, 1'b0, 32'h0000_5010},  // R3 disabled window
        {2'd0, 1'b1, 1'b0, 32'h0000_1500},  // R4 code 0 ignored
        {2'd1, 1'b0, 1'b0, 32'h0000_1500},  // R5 context disabled
        {2'd2, 1'b1, 1'b0, 32'h0000_7FFF},  // R3 gap between windows
        {2'd1, 1'b1, 1'b1, 32'h0000_1800}   // R4 code 1 mid-window
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CFG_AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // presents one event for one cycle; returns at the negedge after the capturing edge
    task automatic fire(input logic [1:0] k, input logic [31:0] ip, input logic cx);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = k; evt_ip = ip; ctx_en = cx;
        @(negedge clk);
        evt_valid = 1'b0; evt_kind = 2'd0;
    endtask

    task automatic drain();
        pkt_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        filt_req = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(stopped == 1'b0, "R1 stopped", 32'(stopped), 0);
        check(trig_en == 1'b0, "R1 trig_en", 32'(trig_en), 0);
        check(pkt_valid == 1'b0, "R1 pkt_valid", 32'(pkt_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(trig_en == 1'b0 && stopped == 1'b0, "R1 after release", 32'(trig_en), 0);
        wr(4, 32'h1000); wr(5, 32'h1FFF);
        fire(2'd1, 32'h1500, 1'b1);
        check(pkt_valid == 1'b0 && stopped == 1'b0, "R1 no window enabled", 32'(pkt_valid), 0);

        wr(6, 32'h8000); wr(7, 32'h8000);
        wr(8, 32'h3000); wr(9, 32'h2000);
        wr(10, 32'h5000); wr(11, 32'h50FF);
        wr(2, 32'h7);
        wr(0, 32'h1);
        check(trig_en == 1'b1, "R2 trig_en on", 32'(trig_en), 1);

        // table walk
        for (int v = 0; v < 12; v++) begin
            logic exp_stop;
            exp_stop = VECS[v][32];
            fire(VECS[v][35:34], VECS[v][31:0], VECS[v][33]);
            check(pkt_valid == exp_stop, "R3 R4 R5 R8 vector pkt_valid", 32'(pkt_valid), 32'(exp_stop));
            check(stopped == exp_stop, "R6 vector stopped", 32'(stopped), 32'(exp_stop));
            check(trig_en == !exp_stop, "R2 vector trig_en", 32'(trig_en), 32'(!exp_stop));
            if (exp_stop) begin
                check(pkt_data == 8'h02, "R8 first byte", 32'(pkt_data), 32'h02);
                drain();
                check(pkt_valid == 1'b0, "R8 packet done", 32'(pkt_valid), 0);
                wr(1, 32'h0);
            end
        end

        // R5 master off: no stop
        wr(0, 32'h0);
        fire(2'd1, 32'h1000, 1'b1);
        check(pkt_valid == 1'b0 && stopped == 1'b0, "R5 master off", 32'(pkt_valid), 0);
        wr(0, 32'h1);

        // R9 stall and R8 sequence
        fire(2'd1, 32'h1100, 1'b1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(pkt_valid && pkt_data == 8'h02, "R9 hold first byte", 32'(pkt_data), 32'h02);
        end
        // R7 filter forced low while stopped
        check(filt_en == 1'b0, "R7 filt_en forced", 32'(filt_en), 0);
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
        check(pkt_valid && pkt_data == 8'h83, "R8 second byte", 32'(pkt_data), 32'h83);
        @(negedge clk);
        check(pkt_valid && pkt_data == 8'h83, "R9 hold second byte", 32'(pkt_data), 32'h83);
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
        check(pkt_valid == 1'b0, "R8 valid drops", 32'(pkt_valid), 0);

        // R10 sticky: further hits while stopped do nothing
        fire(2'd2, 32'h1200, 1'b1);
        check(pkt_valid == 1'b0 && stopped == 1'b1, "R10 no packet while stopped", 32'(pkt_valid), 0);
        repeat (3) @(negedge clk);
        check(stopped == 1'b1, "R6 sticky", 32'(stopped), 1);
        wr(1, 32'h0);
        check(stopped == 1'b0 && filt_en == 1'b1, "R7 filt_en restored", 32'(filt_en), 1);

        // R10 hit during in-flight packet is dropped
        fire(2'd1, 32'h1300, 1'b1);
        wr(1, 32'h0);
        fire(2'd1, 32'h1400, 1'b1);
        check(stopped == 1'b0, "R10 in-flight hit ignored", 32'(stopped), 0);
        drain();
        @(negedge clk);
        check(pkt_valid == 1'b0, "R10 only one packet", 32'(pkt_valid), 0);

        // R6 stop wins over same-cycle status clear
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = 2'd1; evt_ip = 32'h1000; ctx_en = 1'b1;
        cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 32'h0;
        @(negedge clk);
        evt_valid = 1'b0; cfg_we = 1'b0;
        check(stopped == 1'b1 && pkt_valid == 1'b1, "R6 stop beats clear", 32'(stopped), 1);
        drain();
        wr(1, 32'h0);

        // R11 software sets stopped
        wr(1, 32'h1);
        check(stopped == 1'b1 && trig_en == 1'b0, "R11 sw stop trig_en", 32'(trig_en), 0);
        check(pkt_valid == 1'b0, "R11 no packet", 32'(pkt_valid), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule